// File: doc/BRIEF.md
# Programmable Cylinder/Head/Sector to Linear Block Translator

This block turns a host disk address given as cylinder, head and sector into a linear sector number. The mapping follows a logical geometry (head count and sectors per track) that a host may reprogram at run time. After reset the geometry is 8 heads of 32 sectors per track, which over 802 cylinders exactly covers the formatted capacity of 205312 sectors of 512 bytes. The native recording layout (1254 cylinders, 4 heads) is never visible here.

A geometry write carries a cylinder count, a head count and a sectors-per-track value. It is taken only if no field is zero and the product of the three does not exceed the capacity; otherwise the geometry in force stays. A translation request is taken when the block is idle. A shift-and-add multiplier forms `(cylinder * heads + head) * sectors_per_track + (sector - 1)` in two passes, and a single-cycle done pulse then presents either a valid linear address or a range error.

Top module: `chs_lba_xlate`

## Requirements
- R1: After reset done_o, busy_o, valid_o and err_o are 0 and lba_o is 0, and the geometry in force is 8 heads by 32 sectors per track.
- R2: For an in-range request the result is lba_o = (cylinder * heads + head) * sectors_per_track + sector - 1, with valid_o = 1 and err_o = 0; sectors are numbered from 1.
- R3: A request sampled at a clock edge while busy_o is 0 produces a done_o pulse of exactly one cycle after the 18th following edge; busy_o is 1 in between and falls at the edge that raises done_o.
- R4: A request with sector 0 ends with err_o = 1.
- R5: A request whose head is at or above the head count ends with err_o = 1.
- R6: A request whose sector is above sectors_per_track ends with err_o = 1.
- R7: A request whose computed address is 205312 or more ends with err_o = 1; valid results are always below 205312.
- R8: When done_o is 1 exactly one of valid_o and err_o is 1, and lba_o is 0 whenever err_o is 1.
- R9: A geometry write with all fields non-zero and cylinders * heads * sectors_per_track at most 205312 is applied at its clock edge and governs requests sampled at later edges.
- R10: A geometry write with a zero field or a product above 205312 is refused and the previous geometry stays in force.
- R11: A request presented while busy_o is 1 is ignored: the running result is unchanged and no extra done_o pulse follows.
- R12: A geometry write accepted while a translation is running does not alter that translation's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| geo_we_i | input | 1 | Geometry write strobe |
| geo_cyls_i | input | 16 | Cylinder count of the proposed geometry |
| geo_heads_i | input | 5 | Head count of the proposed geometry |
| geo_spt_i | input | 8 | Sectors per track of the proposed geometry |
| req_i | input | 1 | Translation request |
| cyl_i | input | 16 | Requested cylinder |
| head_i | input | 5 | Requested head |
| sec_i | input | 8 | Requested sector, numbered from 1 |
| busy_o | output | 1 | Translation in progress; requests are ignored |
| done_o | output | 1 | One-cycle result strobe |
| valid_o | output | 1 | Result is a valid linear address |
| err_o | output | 1 | Request was out of range |
| lba_o | output | 30 | Linear sector number, 0 on error |

## Verification
Each result is due on the done pulse after the 18th clock edge following the edge that samples the request: two multiplier passes of 8 steps plus one load edge each, and a result register. The bench drives the request one edge before, stays on negative edges, confirms done_o is still low after edge 17, reads the result after edge 18 and confirms the strobe is gone after edge 19. A geometry write counts from its own edge, so the bench issues the next request after the write's edge. Mid-flight requests and writes are placed at edge 5 so that their effect, or lack of one, shows up in the same result window.

// File: rtl/chs_xlate_pkg.sv
package chs_xlate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MUL_HEADS,
    ST_MUL_SPT
  } xlate_state_e;

  localparam int unsigned CAP_SECTORS = 205312;
  localparam int unsigned DEF_HEADS   = 8;
  localparam int unsigned DEF_SPT     = 32;

  function automatic int unsigned max_w(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/chs_geom_regs.sv
module chs_geom_regs #(
  parameter int unsigned CYL_W     = 16,
  parameter int unsigned HEAD_W    = 5,
  parameter int unsigned SEC_W     = 8,
  parameter int unsigned CAP       = 205312,
  parameter int unsigned DEF_HEADS = 8,
  parameter int unsigned DEF_SPT   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CYL_W-1:0]  cyls_i,
  input  logic [HEAD_W-1:0] heads_i,
  input  logic [SEC_W-1:0]  spt_i,
  output logic [HEAD_W-1:0] heads_o,
  output logic [SEC_W-1:0]  spt_o
);

  localparam int unsigned PROD_W = CYL_W + HEAD_W + SEC_W;

  logic [PROD_W-1:0] prod;
  logic              fits;
  logic [HEAD_W-1:0] heads_q;
  logic [SEC_W-1:0]  spt_q;

  always_comb begin
    prod = PROD_W'(cyls_i) * PROD_W'(heads_i) * PROD_W'(spt_i);
    fits = (|cyls_i) && (|heads_i) && (|spt_i) && (prod <= PROD_W'(CAP));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      heads_q <= HEAD_W'(DEF_HEADS);
      spt_q   <= SEC_W'(DEF_SPT);
    end else if (we_i && fits) begin
      heads_q <= heads_i;
      spt_q   <= spt_i;
    end
  end

  assign heads_o = heads_q;
  assign spt_o   = spt_q;

endmodule

// File: rtl/chs_req_chk.sv
module chs_req_chk #(
  parameter int unsigned HEAD_W = 5,
  parameter int unsigned SEC_W  = 8
) (
  input  logic [HEAD_W-1:0] head_i,
  input  logic [SEC_W-1:0]  sec_i,
  input  logic [HEAD_W-1:0] heads_i,
  input  logic [SEC_W-1:0]  spt_i,
  output logic              bad_o
);

  logic sec_zero, head_over, sec_over;

  always_comb begin
    sec_zero  = (sec_i == '0);
    head_over = (head_i >= heads_i);
    sec_over  = (sec_i > spt_i);
    bad_o     = sec_zero | head_over | sec_over;
  end

endmodule

// File: rtl/chs_seq_mac.sv
// acc = a * b + c, one multiplier bit per cycle, LSB first
module chs_seq_mac #(
  parameter int unsigned A_W = 30,
  parameter int unsigned B_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  input  logic [A_W-1:0] c_i,
  output logic [A_W-1:0] acc_o,
  output logic           done_o
);

  localparam int unsigned CNT_W = $clog2(B_W + 1);

  logic [A_W-1:0]   acc_q, mcand_q;
  logic [B_W-1:0]   mplier_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
      done_q   <= 1'b0;
    end else if (start_i) begin
      acc_q    <= c_i;
      mcand_q  <= a_i;
      mplier_q <= b_i;
      cnt_q    <= CNT_W'(B_W);
      run_q    <= 1'b1;
      done_q   <= 1'b0;
    end else if (run_q) begin
      if (mplier_q[0]) acc_q <= acc_q + mcand_q;
      mcand_q  <= mcand_q << 1;
      mplier_q <= mplier_q >> 1;
      cnt_q    <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign acc_o  = acc_q;
  assign done_o = done_q;

endmodule

// File: rtl/chs_lba_xlate.sv
module chs_lba_xlate
  import chs_xlate_pkg::*;
#(
  parameter int unsigned CYL_W     = 16,
  parameter int unsigned HEAD_W    = 5,
  parameter int unsigned SEC_W     = 8,
  parameter int unsigned CAP       = CAP_SECTORS,
  parameter int unsigned DEF_H     = DEF_HEADS,
  parameter int unsigned DEF_S     = DEF_SPT,
  parameter int unsigned LBA_W     = CYL_W + HEAD_W + SEC_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              geo_we_i,
  input  logic [CYL_W-1:0]  geo_cyls_i,
  input  logic [HEAD_W-1:0] geo_heads_i,
  input  logic [SEC_W-1:0]  geo_spt_i,
  input  logic              req_i,
  input  logic [CYL_W-1:0]  cyl_i,
  input  logic [HEAD_W-1:0] head_i,
  input  logic [SEC_W-1:0]  sec_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              valid_o,
  output logic              err_o,
  output logic [LBA_W-1:0]  lba_o
);

  localparam int unsigned MUL_W = max_w(HEAD_W, SEC_W);

  xlate_state_e      state_q;
  logic [HEAD_W-1:0] heads_cur;
  logic [SEC_W-1:0]  spt_cur, spt_q, sec_q;
  logic              bad_now, bad_q;
  logic              accept;
  logic              mac_start, mac_done;
  logic [LBA_W-1:0]  mac_a, mac_c, mac_acc;
  logic [MUL_W-1:0]  mac_b;
  logic              fin_err;
  logic              done_q, valid_q, err_q;
  logic [LBA_W-1:0]  lba_q;

  chs_geom_regs #(
    .CYL_W(CYL_W), .HEAD_W(HEAD_W), .SEC_W(SEC_W),
    .CAP(CAP), .DEF_HEADS(DEF_H), .DEF_SPT(DEF_S)
  ) geom_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(geo_we_i),
    .cyls_i(geo_cyls_i), .heads_i(geo_heads_i), .spt_i(geo_spt_i),
    .heads_o(heads_cur), .spt_o(spt_cur)
  );

  chs_req_chk #(.HEAD_W(HEAD_W), .SEC_W(SEC_W)) chk_i (
    .head_i(head_i), .sec_i(sec_i),
    .heads_i(heads_cur), .spt_i(spt_cur),
    .bad_o(bad_now)
  );

  assign accept = (state_q == ST_IDLE) && req_i;

  // pass 1: cyl*heads+head, pass 2: (...)*spt + sec-1
  always_comb begin
    mac_start = accept || ((state_q == ST_MUL_HEADS) && mac_done);
    if (state_q == ST_IDLE) begin
      mac_a = LBA_W'(cyl_i);
      mac_b = MUL_W'(heads_cur);
      mac_c = LBA_W'(head_i);
    end else begin
      mac_a = mac_acc;
      mac_b = MUL_W'(spt_q);
      mac_c = (sec_q == '0) ? '0 : LBA_W'(sec_q) - LBA_W'(1);
    end
  end

  chs_seq_mac #(.A_W(LBA_W), .B_W(MUL_W)) mac_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(mac_start),
    .a_i(mac_a), .b_i(mac_b), .c_i(mac_c),
    .acc_o(mac_acc), .done_o(mac_done)
  );

  assign fin_err = bad_q || (mac_acc >= LBA_W'(CAP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sec_q   <= '0;
      spt_q   <= '0;
      bad_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          sec_q   <= sec_i;
          spt_q   <= spt_cur;
          bad_q   <= bad_now;
          state_q <= ST_MUL_HEADS;
        end
        ST_MUL_HEADS: if (mac_done) state_q <= ST_MUL_SPT;
        ST_MUL_SPT:   if (mac_done) state_q <= ST_IDLE;
        default:      state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      lba_q   <= '0;
    end else if ((state_q == ST_MUL_SPT) && mac_done) begin
      done_q  <= 1'b1;
      valid_q <= !fin_err;
      err_q   <= fin_err;
      lba_q   <= fin_err ? '0 : mac_acc;
    end else begin
      done_q  <= 1'b0;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;
  assign lba_o   = lba_q;

endmodule

// File: rtl/chs_lba_xlate_chk.sv
module chs_lba_xlate_chk
  import chs_xlate_pkg::*;
#(
  parameter int unsigned CYL_W  = 16,
  parameter int unsigned HEAD_W = 5,
  parameter int unsigned SEC_W  = 8,
  parameter int unsigned CAP    = CAP_SECTORS,
  parameter int unsigned LBA_W  = CYL_W + HEAD_W + SEC_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             valid_o,
  input logic             err_o,
  input logic [LBA_W-1:0] lba_o
);

  localparam int unsigned LAT   = 2 * max_w(HEAD_W, SEC_W) + 2;
  localparam int unsigned CNT_W = $clog2(LAT + 2) + 1;

  logic [CNT_W-1:0] lat_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lat_cnt <= '0;
    else if (req_i && !busy_o)  lat_cnt <= CNT_W'(1);
    else if (busy_o)            lat_cnt <= lat_cnt + 1'b1;
  end

  p_done_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_cnt == CNT_W'(LAT + 1)));

  p_busy_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_one_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (valid_o ^ err_o));

  p_err_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (lba_o == '0));

  p_below_cap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && valid_o) |-> (lba_o < LBA_W'(CAP)));

  p_ignore_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_i && (lat_cnt < CNT_W'(LAT))) |=> busy_o);

endmodule

bind chs_lba_xlate chs_lba_xlate_chk #(
  .CYL_W(CYL_W), .HEAD_W(HEAD_W), .SEC_W(SEC_W), .CAP(CAP), .LBA_W(LBA_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .busy_o(busy_o),
  .done_o(done_o), .valid_o(valid_o), .err_o(err_o), .lba_o(lba_o)
);

// File: tb/chs_lba_xlate_tb_top.sv
module chs_lba_xlate_tb_top;

  localparam longint CAPL = 205312;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        geo_we = 1'b0;
  logic [15:0] geo_cyls = '0;
  logic [4:0]  geo_heads = '0;
  logic [7:0]  geo_spt = '0;
  logic        req = 1'b0;
  logic [15:0] cyl = '0;
  logic [4:0]  head = '0;
  logic [7:0]  sec = '0;
  logic        busy, done, valid, err;
  logic [29:0] lba;

  int checks = 0;
  int errors = 0;
  int m_heads = 8;
  int m_spt = 32;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  chs_lba_xlate dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .geo_we_i(geo_we), .geo_cyls_i(geo_cyls), .geo_heads_i(geo_heads), .geo_spt_i(geo_spt),
    .req_i(req), .cyl_i(cyl), .head_i(head), .sec_i(sec),
    .busy_o(busy), .done_o(done), .valid_o(valid), .err_o(err), .lba_o(lba)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic write_geo(input int c, input int h, input int s);
    @(negedge clk);
    geo_we = 1'b1; geo_cyls = 16'(c); geo_heads = 5'(h); geo_spt = 8'(s);
    @(posedge clk);
    @(negedge clk);
    geo_we = 1'b0;
    if (c > 0 && h > 0 && s > 0 && longint'(c) * h * s <= CAPL) begin
      m_heads = h; m_spt = s;
    end
  endtask

  // mid: 0 none, 1 stray request at edge 5, 2 geometry write at edge 5
  task automatic xlate(input int c, input int h, input int s, input string rq,
                       input int mid, input int mc, input int mh, input int ms);
    longint exp_lba;
    bit     exp_err;
    int     extra;
    exp_lba = (longint'(c) * m_heads + h) * m_spt + s - 1;
    exp_err = (s == 0) || (h >= m_heads) || (s > m_spt) || (exp_lba >= CAPL);
    @(negedge clk);
    req = 1'b1; cyl = 16'(c); head = 5'(h); sec = 8'(s);
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    for (int i = 1; i <= 17; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i == 4 && mid == 1) begin
        req = 1'b1; cyl = 16'(mc); head = 5'(mh); sec = 8'(ms);
      end
      if (i == 4 && mid == 2) begin
        geo_we = 1'b1; geo_cyls = 16'(mc); geo_heads = 5'(mh); geo_spt = 8'(ms);
      end
      if (i == 5) begin
        req = 1'b0;
        if (mid == 2) begin
          geo_we = 1'b0;
          if (mc > 0 && mh > 0 && ms > 0 && longint'(mc) * mh * ms <= CAPL) begin
            m_heads = mh; m_spt = ms;
          end
        end
      end
      if (i == 17) begin
        chk(!done, "R3 early done", done, 0);
        chk(busy, "R3 busy during run", busy, 1);
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(done, {rq, " R3 done due"}, done, 1);
    chk(!busy, "R3 busy released", busy, 0);
    chk(err == exp_err, {rq, " err flag"}, err, exp_err);
    chk(valid == !exp_err, {rq, " R8 valid flag"}, valid, !exp_err);
    chk(lba == (exp_err ? 0 : exp_lba), {rq, " lba"}, lba, exp_err ? 0 : exp_lba);
    @(posedge clk);
    @(negedge clk);
    chk(!done, "R3 single pulse", done, 0);
    if (mid == 1) begin
      extra = 0;
      for (int i = 0; i < 24; i++) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk(extra == 0, "R11 stray done pulses", extra, 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !busy && !valid && !err, "R1 flags at reset", {done, busy, valid, err}, 0);
    chk(lba == 0, "R1 lba at reset", lba, 0);
    rst_n = 1'b1;

    // R1 default geometry, R2 formula, R7 top of capacity
    xlate(0, 0, 1, "R1 R2 first sector", 0, 0, 0, 0);
    xlate(1, 0, 1, "R1 R2 next cylinder", 0, 0, 0, 0);
    xlate(801, 7, 32, "R2 R7 last sector", 0, 0, 0, 0);
    xlate(802, 0, 1, "R7 beyond capacity", 0, 0, 0, 0);
    xlate(65535, 31, 255, "R7 R5 extreme", 0, 0, 0, 0);
    xlate(0, 0, 0, "R4 sector zero", 0, 0, 0, 0);
    xlate(0, 8, 1, "R5 head at count", 0, 0, 0, 0);
    xlate(3, 2, 33, "R6 sector above track", 0, 0, 0, 0);

    // R10 refused geometries keep 8x32
    write_geo(803, 8, 32);
    xlate(1, 0, 1, "R10 oversize refused", 0, 0, 0, 0);
    write_geo(10, 0, 4);
    xlate(2, 7, 32, "R10 zero heads refused", 0, 0, 0, 0);
    write_geo(0, 4, 4);
    xlate(0, 7, 1, "R10 zero cylinders refused", 0, 0, 0, 0);

    // R9 geometry exactly at capacity
    write_geo(401, 16, 32);
    xlate(0, 15, 32, "R9 sixteen heads", 0, 0, 0, 0);
    xlate(400, 15, 32, "R9 R7 last sector", 0, 0, 0, 0);
    xlate(401, 0, 1, "R9 R7 past end", 0, 0, 0, 0);

    // R2 sweep over a small geometry
    write_geo(4, 3, 5);
    for (int c = 0; c < 6; c++)
      for (int h = 0; h < 5; h++)
        for (int s = 0; s < 7; s++)
          xlate(c, h, s, "R2 R4 R5 R6 sweep", 0, 0, 0, 0);

    // R11 stray request mid-flight
    xlate(2, 1, 3, "R11 first result kept", 1, 3, 2, 4);

    // R12 geometry write mid-flight, then new geometry used
    xlate(2, 1, 3, "R12 in-flight unchanged", 2, 10, 4, 6);
    xlate(2, 1, 3, "R12 R9 new geometry", 0, 0, 0, 0);
    chk(m_heads == 4 && m_spt == 6, "R12 model geometry", m_heads, 4);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule